// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Registers

This block controls 32 general-purpose pins behind a small 32-bit register bus. The pins form two banks of sixteen. Every per-pin control register takes a paired write word. A 1 in the lower half turns a pin's feature on and a 1 in the upper half turns it off. Software can therefore change one pin with a single write, and no read-modify-write of the whole register is needed. The per-pin features are output value, output enable, input enable, two output-alternate selects and one input-alternate select.

Pad inputs are resynchronised and then read back. Rising and falling transitions are latched in status registers that software clears by writing ones. Each pin also carries a 4-bit event-routing field. Three bits of that field pick one of eight event pairs and one bit flags a power-management event. The routing fields and the alternate selects leave the block as plain select vectors, which neighbouring logic uses. Four pin positions are reserved and hold no state.

Top module: `gpio_pair_bank`

## Requirements
- R1: Address bit 7 selects the bank: 0 selects pins 0–15 and 1 selects pins 16–31, so each high-bank register sits 0x80 above its low-bank twin. Word offsets in a bank: 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C output-alternate 1, 0x10 output-alternate 2, 0x14 input-alternate 1, 0x18 pin level, 0x1C rising status, 0x20 falling status. Address bits 1:0 are ignored.
- R2: A write to a control register (offsets 0x00–0x14) sets the feature of bank pin n when write bit n is 1, and clears it when write bit n+16 is 1.
- R3: In such a write, a pin whose set bit and clear bit are both 0 keeps its value.
- R4: When both the set bit and the clear bit of one pin are 1, the clear wins.
- R5: A read strobe returns that bank's per-pin state in read-data bits 15:0, with bits 31:16 at 0, on the cycle after the strobe. Read data holds between strobes.
- R6: Pad inputs pass through two flip-flops before they reach the level register and the edge detectors. A pad change therefore shows in the level register only after two clock edges. A rising or falling edge is latched only for pins whose input enable is 1.
- R7: Writing 1 to bit n (15:0) of a status register clears that pin's latched edge. Bits 31:16 of the write do nothing. An edge that arrives in the same cycle as its clear stays latched.
- R8: Four event-routing words live in the low bank at 0x40, 0x44, 0x48 and 0x4C. They cover pins 0–7, 8–15, 16–23 and 24–31. Pin p's field is bits (p mod 8)·4+3 down to (p mod 8)·4: bits 2:0 pick the event pair and bit 3 flags power management. These words are written whole and read back as written. They also appear on the `evt_map` output, with pin p's field at bits 4p+3:4p.
- R9: Pins 23, 29, 30 and 31 are reserved. All of their control, status, level and event-routing bits read as 0 and ignore writes.
- R10: A pad is driven (its `pad_oe` bit is 1) only when its output enable is 1 and neither output-alternate select is 1. While it is driven, `pad_out` carries the output value. Otherwise `pad_out` is 0.
- R11: After reset, every register and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables (0 = high impedance) |
| alt_out1_en | output | 32 | Output-alternate 1 select per pin |
| alt_out2_en | output | 32 | Output-alternate 2 select per pin |
| alt_in1_en | output | 32 | Input-alternate 1 select per pin |
| evt_map | output | 128 | Event-routing fields, 4 bits per pin |

## Verification
The hardest case to reach from the ports is a pad edge that lands in the same clock as the software write that clears it. The bench makes this happen by changing a pad on a falling clock edge and then waiting exactly one cycle. It then issues the W1C write so that its strobe is sampled on the third rising edge, which is the edge where the two-flop synchronizer delivers the new level to the edge detector. The same sync depth is checked separately. A level read issued right after a pad change must still return the old value, and the read after it must return the new one.

// File: rtl/gpio_pair_pkg.sv
// Package: shared sizes, register word offsets and the set/clear write layout
// for the dual-bank GPIO controller.
package gpio_pair_pkg;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int BANK_PINS    = 16;
    localparam int NUM_BANKS    = 2;
    localparam int NUM_PINS     = BANK_PINS * NUM_BANKS;
    localparam int NUM_CTL      = 6;
    localparam int EVT_BITS     = 4;
    localparam int EVT_PER_REG  = DATA_W / EVT_BITS;
    localparam int NUM_EVT_REGS = NUM_PINS / EVT_PER_REG;
    localparam int EG_W         = $clog2(NUM_EVT_REGS);
    localparam int WORD_W       = ADDR_W - 3;

    // control register indices (word offset inside a bank)
    localparam int CTL_OVAL  = 0;
    localparam int CTL_OEN   = 1;
    localparam int CTL_IEN   = 2;
    localparam int CTL_OALT1 = 3;
    localparam int CTL_OALT2 = 4;
    localparam int CTL_IALT1 = 5;

    localparam logic [WORD_W-1:0] WD_LEVEL = WORD_W'(6);
    localparam logic [WORD_W-1:0] WD_RISE  = WORD_W'(7);
    localparam logic [WORD_W-1:0] WD_FALL  = WORD_W'(8);
    // event-routing base; aligned so low word bits index the group
    localparam logic [WORD_W-1:0] WD_EVMAP = WORD_W'(16);

    // paired write word: upper half clears, lower half sets
    typedef struct packed {
        logic [BANK_PINS-1:0] clr;
        logic [BANK_PINS-1:0] set;
    } setclr_word_t;
endpackage

// File: rtl/gpio_setclr_reg.sv
// Module: one bank's worth of a set/clear control register.
// Assumes: wr_en is a single-cycle strobe already qualified by address.
// Clear has priority over set; bits with KEEP=0 are held at zero.
module gpio_setclr_reg
    import gpio_pair_pkg::*;
#(
    parameter logic [BANK_PINS-1:0] KEEP = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  setclr_word_t         wdata,
    output logic [BANK_PINS-1:0] q
);
    // apply set then clear to the stored bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= ((q | wdata.set) & ~wdata.clr) & KEEP;
    end
endmodule

// File: rtl/gpio_edge_bank.sv
// Module: pad input synchronizer, level register and edge status for one bank.
// Assumes: pad_in is asynchronous; two flops give the synchronized level and
// a third holds the previous level for edge detection. A new edge wins over
// a clear in the same cycle.
module gpio_edge_bank
    import gpio_pair_pkg::*;
#(
    parameter logic [BANK_PINS-1:0] KEEP = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_PINS-1:0] pad_in,
    input  logic [BANK_PINS-1:0] in_en,
    input  logic                 rise_clr_we,
    input  logic                 fall_clr_we,
    input  logic [BANK_PINS-1:0] clr_bits,
    output logic [BANK_PINS-1:0] level,
    output logic [BANK_PINS-1:0] rise_sts,
    output logic [BANK_PINS-1:0] fall_sts
);
    logic [BANK_PINS-1:0] sync_a;
    logic [BANK_PINS-1:0] sync_b;
    logic [BANK_PINS-1:0] prev_b;
    logic [BANK_PINS-1:0] rise_hit;
    logic [BANK_PINS-1:0] fall_hit;
    logic [BANK_PINS-1:0] rise_clr;
    logic [BANK_PINS-1:0] fall_clr;

    // two-stage synchronizer plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            prev_b <= '0;
        end else begin
            sync_a <= pad_in;
            sync_b <= sync_a;
            prev_b <= sync_b;
        end
    end

    // qualified edge detection and clear masks
    always_comb begin
        rise_hit = sync_b & ~prev_b & in_en & KEEP;
        fall_hit = ~sync_b & prev_b & in_en & KEEP;
        rise_clr = rise_clr_we ? clr_bits : '0;
        fall_clr = fall_clr_we ? clr_bits : '0;
    end

    // latch edges; write-one-to-clear with edge priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_sts <= '0;
            fall_sts <= '0;
        end else begin
            rise_sts <= (rise_sts & ~rise_clr) | rise_hit;
            fall_sts <= (fall_sts & ~fall_clr) | fall_hit;
        end
    end

    assign level = sync_b & KEEP;
endmodule

// File: rtl/gpio_evmap.sv
// Module: event-routing words, one 4-bit field per pin, written whole.
// Assumes: grp selects the word; fields of pins with KEEP=0 read as zero.
module gpio_evmap
    import gpio_pair_pkg::*;
#(
    parameter logic [NUM_PINS-1:0] KEEP = '1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [EG_W-1:0]                  grp,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_EVT_REGS*DATA_W-1:0]   map
);
    // widen one pin-keep bit per field into a nibble mask
    function automatic logic [DATA_W-1:0] nib_keep(input logic [EVT_PER_REG-1:0] pk);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int p = 0; p < EVT_PER_REG; p++)
            r[p*EVT_BITS +: EVT_BITS] = {EVT_BITS{pk[p]}};
        return r;
    endfunction

    for (genvar g = 0; g < NUM_EVT_REGS; g++) begin : g_word
        localparam logic [DATA_W-1:0] GKEEP = nib_keep(KEEP[g*EVT_PER_REG +: EVT_PER_REG]);
        // load the whole routing word on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                map[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && grp == EG_W'(g))
                map[g*DATA_W +: DATA_W] <= wdata & GKEEP;
        end
    end
endmodule

// File: rtl/gpio_pair_bank.sv
// Module: dual-bank GPIO controller top. Decodes the register bus, holds
// per-bank set/clear controls, edge status and level, routing words, and
// drives pad enables. Assumes single-cycle strobes and registered read data.
module gpio_pair_bank
    import gpio_pair_pkg::*;
#(
    parameter logic [NUM_PINS-1:0] RESV_MASK = 32'hE080_0000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_PINS-1:0]            pad_in,
    output logic [NUM_PINS-1:0]            pad_out,
    output logic [NUM_PINS-1:0]            pad_oe,
    output logic [NUM_PINS-1:0]            alt_out1_en,
    output logic [NUM_PINS-1:0]            alt_out2_en,
    output logic [NUM_PINS-1:0]            alt_in1_en,
    output logic [NUM_EVT_REGS*DATA_W-1:0] evt_map
);
    localparam logic [NUM_PINS-1:0] KEEP_ALL = ~RESV_MASK;

    logic                  bank_sel;
    logic [WORD_W-1:0]     bus_word;
    logic                  evm_hit;
    logic [EG_W-1:0]       evm_grp;
    logic                  unused_addr_lsb;

    logic [BANK_PINS-1:0]  ctl_bk   [NUM_BANKS][NUM_CTL];
    logic [BANK_PINS-1:0]  level_bk [NUM_BANKS];
    logic [BANK_PINS-1:0]  rise_bk  [NUM_BANKS];
    logic [BANK_PINS-1:0]  fall_bk  [NUM_BANKS];

    logic [NUM_PINS-1:0]   oval_all;
    logic [NUM_PINS-1:0]   oen_all;
    logic [NUM_PINS-1:0]   ien_all;
    logic [NUM_PINS-1:0]   alt1_all;
    logic [NUM_PINS-1:0]   alt2_all;
    logic [NUM_PINS-1:0]   ialt_all;
    logic [NUM_PINS-1:0]   rise_all;
    logic [NUM_PINS-1:0]   fall_all;

    logic [DATA_W-1:0]     rd_mux;

    // address split: bank bit, word index, routing-group index
    always_comb begin
        bank_sel = bus_addr[ADDR_W-1];
        bus_word = bus_addr[ADDR_W-2:2];
        evm_hit  = !bank_sel && (bus_word >= WD_EVMAP)
                   && (bus_word < WD_EVMAP + WORD_W'(NUM_EVT_REGS));
        evm_grp  = bus_word[EG_W-1:0];
    end
    assign unused_addr_lsb = ^bus_addr[1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_PINS-1:0] BKEEP = KEEP_ALL[b*BANK_PINS +: BANK_PINS];

        for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
            gpio_setclr_reg #(.KEEP(BKEEP)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (bus_wr && bank_sel == 1'(b) && bus_word == WORD_W'(c)),
                .wdata (setclr_word_t'(bus_wdata)),
                .q     (ctl_bk[b][c])
            );
        end

        gpio_edge_bank #(.KEEP(BKEEP)) u_edge (
            .clk         (clk),
            .rst_n       (rst_n),
            .pad_in      (pad_in[b*BANK_PINS +: BANK_PINS]),
            .in_en       (ctl_bk[b][CTL_IEN]),
            .rise_clr_we (bus_wr && bank_sel == 1'(b) && bus_word == WD_RISE),
            .fall_clr_we (bus_wr && bank_sel == 1'(b) && bus_word == WD_FALL),
            .clr_bits    (bus_wdata[BANK_PINS-1:0]),
            .level       (level_bk[b]),
            .rise_sts    (rise_bk[b]),
            .fall_sts    (fall_bk[b])
        );

        // gather bank slices into full-width per-feature vectors
        assign oval_all[b*BANK_PINS +: BANK_PINS] = ctl_bk[b][CTL_OVAL];
        assign oen_all [b*BANK_PINS +: BANK_PINS] = ctl_bk[b][CTL_OEN];
        assign ien_all [b*BANK_PINS +: BANK_PINS] = ctl_bk[b][CTL_IEN];
        assign alt1_all[b*BANK_PINS +: BANK_PINS] = ctl_bk[b][CTL_OALT1];
        assign alt2_all[b*BANK_PINS +: BANK_PINS] = ctl_bk[b][CTL_OALT2];
        assign ialt_all[b*BANK_PINS +: BANK_PINS] = ctl_bk[b][CTL_IALT1];
        assign rise_all[b*BANK_PINS +: BANK_PINS] = rise_bk[b];
        assign fall_all[b*BANK_PINS +: BANK_PINS] = fall_bk[b];
    end

    gpio_evmap #(.KEEP(KEEP_ALL)) u_evmap (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && evm_hit),
        .grp   (evm_grp),
        .wdata (bus_wdata),
        .map   (evt_map)
    );

    // read multiplexer over controls, level, status and routing words
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CTL; c++)
            if (bus_word == WORD_W'(c))
                rd_mux = {{(DATA_W-BANK_PINS){1'b0}}, ctl_bk[bank_sel][c]};
        if (bus_word == WD_LEVEL)
            rd_mux = {{(DATA_W-BANK_PINS){1'b0}}, level_bk[bank_sel]};
        if (bus_word == WD_RISE)
            rd_mux = {{(DATA_W-BANK_PINS){1'b0}}, rise_bk[bank_sel]};
        if (bus_word == WD_FALL)
            rd_mux = {{(DATA_W-BANK_PINS){1'b0}}, fall_bk[bank_sel]};
        if (evm_hit)
            for (int g = 0; g < NUM_EVT_REGS; g++)
                if (evm_grp == EG_W'(g))
                    rd_mux = evt_map[g*DATA_W +: DATA_W];
    end

    // capture read data on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    // pad drive: own output only when enabled and no alternate claims it
    always_comb begin
        pad_oe  = oen_all & ~alt1_all & ~alt2_all;
        pad_out = oval_all & pad_oe;
    end

    assign alt_out1_en = alt1_all;
    assign alt_out2_en = alt2_all;
    assign alt_in1_en  = ialt_all;
endmodule

// File: rtl/gpio_pair_bank_chk.sv
// Module: property checker bound to the GPIO controller top.
// Assumes: the bound signals are the full-width per-feature vectors.
module gpio_pair_bank_chk
    import gpio_pair_pkg::*;
#(
    parameter logic [NUM_PINS-1:0] RESV_MASK = 32'hE080_0000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   oval_all,
    input logic [NUM_PINS-1:0]   oen_all,
    input logic [NUM_PINS-1:0]   ien_all,
    input logic [NUM_PINS-1:0]   alt1_all,
    input logic [NUM_PINS-1:0]   alt2_all,
    input logic [NUM_PINS-1:0]   ialt_all,
    input logic [NUM_PINS-1:0]   rise_all,
    input logic [NUM_PINS-1:0]   fall_all
);
    // R4: after a low-bank output-value write, no pin marked for clearing is 1
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00) |=>
        ((oval_all[15:0] & $past(bus_wdata[31:16])) == 16'h0));

    // R3: pins with neither set nor clear bit keep their value
    a_r3_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00) |=>
        (((oval_all[15:0] ^ $past(oval_all[15:0]))
          & ~($past(bus_wdata[15:0]) | $past(bus_wdata[31:16]))) == 16'h0));

    // R5: read data only changes after a read strobe
    a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R6: a newly latched rising edge needs input enable
    a_r6_rise_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_all & ~$past(rise_all) & ~$past(ien_all)) == '0));

    // R9: reserved pins hold no state
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (((oval_all | oen_all | ien_all | alt1_all | alt2_all | ialt_all
           | rise_all | fall_all) & RESV_MASK) == '0));

    // R10: a pad is only driven when its output enable is set
    a_r10_oe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~oen_all) == '0));

    // R10: an alternate select always releases the pad and its value
    a_r10_alt_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe | pad_out) & (alt1_all | alt2_all)) == '0));
endmodule

bind gpio_pair_bank gpio_pair_bank_chk #(.RESV_MASK(RESV_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .oval_all  (oval_all),
    .oen_all   (oen_all),
    .ien_all   (ien_all),
    .alt1_all  (alt1_all),
    .alt2_all  (alt2_all),
    .ialt_all  (ialt_all),
    .rise_all  (rise_all),
    .fall_all  (fall_all)
);

// File: tb/tb_gpio_pair_bank.sv
`timescale 1ns/1ps
// Bench: vector table of write/read pairs, then directed tests for reset,
// pad drive, sync depth, edge status and the edge/clear collision.
module tb_gpio_pair_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic [31:0]  pad_in = '0;
    logic [31:0]  pad_out;
    logic [31:0]  pad_oe;
    logic [31:0]  alt_out1_en;
    logic [31:0]  alt_out2_en;
    logic [31:0]  alt_in1_en;
    logic [127:0] evt_map;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    gpio_pair_bank dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
        .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
        .alt_out1_en (alt_out1_en), .alt_out2_en (alt_out2_en),
        .alt_in1_en (alt_in1_en), .evt_map (evt_map)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NVEC = 10;
    localparam logic [79:0] VECS [NVEC] = '{
        {8'h00, 32'h0000_00FF, 8'h00, 32'h0000_00FF},  // R2 set
        {8'h00, 32'h000F_0000, 8'h00, 32'h0000_00F0},  // R2 clear
        {8'h00, 32'h0001_0003, 8'h00, 32'h0000_00F2},  // R4 clear wins
        {8'h80, 32'h0000_FFFF, 8'h80, 32'h0000_1F7F},  // R1 high bank, R9 reserved
        {8'h80, 32'hFFFF_0000, 8'h80, 32'h0000_0000},  // R1 high bank clear
        {8'h04, 32'h0000_8001, 8'h04, 32'h0000_8001},  // R2 output enable
        {8'h08, 32'h0000_1234, 8'h08, 32'h0000_1234},  // R2 input enable
        {8'h08, 32'h0000_0000, 8'h08, 32'h0000_1234},  // R3 zero word no change
        {8'h40, 32'h8765_4321, 8'h40, 32'h8765_4321},  // R8 routing word
        {8'h4C, 32'hFFFF_FFFF, 8'h4C, 32'h000F_FFFF}   // R8/R9 reserved nibbles
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 pad_oe", pad_oe, 32'h0);
        check("R11 evt_map", evt_map[31:0], 32'h0);
        bus_read(8'h00, rv); check("R11 oval", rv, 32'h0);
        bus_read(8'h1C, rv); check("R11 rise", rv, 32'h0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i][79:72], VECS[i][71:40]);
            bus_read(VECS[i][39:32], rv);
            check($sformatf("R2/R3/R4/R8/R9 vec %0d", i), rv, VECS[i][31:0]);
        end
        check("R8 evt_map port", evt_map[31:0], 32'h8765_4321);
        bus_write(8'h48, 32'hFFFF_FFFF);
        check("R8 R9 pin23 field", evt_map[95:64], 32'h0FFF_FFFF);
        bus_write(8'h44, 32'h1111_1111);
        check("R8 word1 untouched by word2", evt_map[63:32], 32'h1111_1111);

        // R1 address bits 1:0 ignored, alt-in select on the port
        bus_write(8'h17, 32'h0000_0003);
        bus_write(8'h94, 32'h0000_0001);
        check("R1 alt_in1 port", alt_in1_en, 32'h0001_0003);

        // R10 pad drive (oval 0x00F2, oen 0x8001 so far)
        bus_write(8'h00, 32'h0000_8000);
        check("R10 pad_oe", pad_oe, 32'h0000_8001);
        check("R10 pad_out", pad_out, 32'h0000_8000);
        bus_write(8'h0C, 32'h0000_8000);
        check("R10 alt1 release oe", pad_oe, 32'h0000_0001);
        check("R10 alt1 release out", pad_out, 32'h0);
        bus_write(8'h0C, 32'h8000_0000);
        bus_write(8'h10, 32'h0000_0001);
        check("R10 alt2 release oe", pad_oe, 32'h0000_8000);
        check("R10 alt2 out", pad_out, 32'h0000_8000);

        // R6 level readback and sync depth
        pad_in = 32'hFFFF_A5A5;
        settle();
        bus_read(8'h18, rv); check("R6 level low", rv, 32'h0000_A5A5);
        bus_read(8'h98, rv); check("R6 R9 level high", rv, 32'h0000_1F7F);
        pad_in[15:0] = 16'h5A5A;
        bus_read(8'h18, rv); check("R6 sync still old", rv, 32'h0000_A5A5);
        bus_read(8'h18, rv); check("R6 sync new", rv, 32'h0000_5A5A);

        // R6/R7 edge status
        bus_write(8'h08, 32'hFFFF_0000);
        pad_in[15:0] = 16'h0000;
        settle();
        bus_write(8'h1C, 32'h0000_FFFF);
        bus_write(8'h20, 32'h0000_FFFF);
        bus_read(8'h1C, rv); check("R7 rise cleared", rv, 32'h0);
        bus_write(8'h08, 32'h0000_00FF);
        pad_in[15:0] = 16'h0F0F;
        settle();
        bus_read(8'h1C, rv); check("R6 rise gated", rv, 32'h0000_000F);
        bus_read(8'h20, rv); check("R6 no fall yet", rv, 32'h0);
        pad_in[15:0] = 16'h0000;
        settle();
        bus_read(8'h20, rv); check("R6 fall gated", rv, 32'h0000_000F);
        bus_write(8'h1C, 32'h0000_0005);
        bus_read(8'h1C, rv); check("R7 w1c", rv, 32'h0000_000A);
        bus_write(8'h1C, 32'h000A_0000);
        bus_read(8'h1C, rv); check("R7 high half ignored", rv, 32'h0000_000A);

        // R7 edge and clear in the same cycle: edge stays
        pad_in[2] = 1'b1;
        @(negedge clk);
        bus_write(8'h1C, 32'h0000_0004);
        bus_read(8'h1C, rv); check("R7 edge beats clear", rv, 32'h0000_000E);

        // R6 high bank with input enable off, then on
        pad_in[31:16] = 16'h0000;
        settle();
        bus_read(8'hA0, rv); check("R6 high fall disabled", rv, 32'h0);
        bus_write(8'h88, 32'h0000_0001);
        pad_in[16] = 1'b1;
        settle();
        bus_read(8'h9C, rv); check("R1 R6 high rise", rv, 32'h0000_0001);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule